// File: doc/BRIEF.md
# Eight-Way Set-Associative Tag Directory with Physical Tag Compare

This block is the directory and lookup section of a 32 KB data cache. The cache has 64 sets, 8 ways and 64-byte lines. A lookup takes the set index from address bits 11:6 of the virtual address, before translation. The physical page number arrives one cycle later from the translation unit, and the block compares it with all eight stored tags of the selected set at once. The cache is therefore virtually indexed and physically tagged. The result reports hit or miss, the way that hit and the MESI state of that line. A miss is the cue for the next level to service the request.

Each line has a 24-bit tag and a 2-bit MESI state. A line is valid whenever its state is not Invalid. To install a line, a fill port writes a tag and a state into a way that the block picks itself. The block offers the lowest-numbered Invalid way first. When all eight ways are valid, it falls back to a per-set tree pseudo-LRU. A separate update port rewrites the state of one line, chosen by set and way, and leaves its tag as it is. Line data, the bus side and the coherence engine sit outside this block.

Top module: `vipt_tag_dir`

## Requirements
- R1: `lk_vidx` carries virtual address bits 11:6 and selects one of the 64 sets. Lines in different sets never answer for each other.
- R2: The stored tag is the full 24-bit physical page number. A lookup whose page number differs from a stored tag in any single bit does not hit that line.
- R3: A hit needs a matching tag on a line whose state is not Invalid (code 0). For every lookup, exactly one of `res_hit` and `res_miss` is high while `res_valid` is high. Both are low when `res_valid` is low.
- R4: The block samples a request at clock edge k and samples `lk_ppn` at edge k+1. It presents `res_valid` together with hit or miss after edge k+1, for one cycle.
- R5: On a hit, `res_way` gives the matching way. `res_state` gives that line's state, encoded I=0, S=1, E=2, M=3.
- R6: A fill writes `fill_tag` and `fill_state` into the way shown on `vict_way` for `fill_set` in the same cycle.
- R7: While the set addressed by `fill_set` contains an Invalid line, `vict_way` names the lowest-numbered Invalid way.
- R8: When all eight ways of the set are valid, `vict_way` follows a tree pseudo-LRU (node bit 0 points to the lower half). Every fill and every hit steers the touched node bits away from the touched way. A fill wins the single update slot over a hit in the same cycle.
- R9: An update writes `upd_state` into the line at (`upd_set`, `upd_way`) and leaves its tag unchanged. A fill to the same line in the same cycle takes precedence.
- R10: After reset, every line is Invalid, no result is presented, and `vict_way` is 0 for every set.
- R11: Address 0x800010a0 uses set 2, and its page number 524289 hits a line filled with that tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vidx | input | 6 | Set index from virtual address bits 11:6 |
| lk_ppn | input | 24 | Translated page number, one cycle after the request |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Lookup hit |
| res_miss | output | 1 | Lookup missed; forward to the next level |
| res_way | output | 3 | Way that hit |
| res_state | output | 2 | MESI state of the line that hit |
| fill_en | input | 1 | Install a line |
| fill_set | input | 6 | Set to install into; also selects the set for `vict_way` |
| fill_tag | input | 24 | Tag to install |
| fill_state | input | 2 | State to install |
| vict_way | output | 3 | Way a fill to `fill_set` would use |
| upd_en | input | 1 | Rewrite one line's state |
| upd_set | input | 6 | Set of the line to rewrite |
| upd_way | input | 3 | Way of the line to rewrite |
| upd_state | input | 2 | New state |

## Verification
A lookup result is due two edges after the request edge, because the set row and the result are both registered. The bench raises the request on one falling edge and supplies the page number on the next falling edge. It reads `res_*` on the falling edge after that, when the outputs are stable. `vict_way` is combinational on `fill_set` and the stored state, so the bench checks it after driving the set and before the edge that performs the fill. State and pseudo-LRU effects of a fill or an update become visible from the cycle after that edge. The bench observes them through the next lookup or the next victim choice.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;
endpackage

// File: rtl/tagdir_cmp.sv
// Parallel tag compare over one set row, with a priority encoder for the way.
module tagdir_cmp #(
  parameter int WAYS  = 8,
  parameter int PPN_W = 24,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][PPN_W-1:0] row_tags,
  input  logic [WAYS-1:0]            row_valid,
  input  logic [PPN_W-1:0]           ppn,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = row_valid[w] && (row_tags[w] == ppn);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/tagdir_plru.sv
// Per-set tree pseudo-LRU storage, with victim selection that takes Invalid ways first.
module tagdir_plru #(
  parameter int SETS = 64,
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] qry_set,
  input  logic [WAYS-1:0]  qry_valid,
  output logic [WAY_W-1:0] victim,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way
);
  logic [WAYS-2:0] tree_q [SETS];
  logic [WAYS-2:0] tree_d;
  logic [WAYS-2:0] qry_tree;
  logic [WAY_W-1:0] tree_way;
  logic [WAY_W-1:0] inv_way;
  logic             any_inv;

  // Victim choice: first Invalid way, otherwise walk the tree.
  always_comb begin
    int node;
    qry_tree = tree_q[qry_set];
    node = 1;
    for (int l = 0; l < WAY_W; l++) begin
      node = node * 2 + int'(qry_tree[node-1]);
    end
    tree_way = WAY_W'(node - WAYS);
    inv_way  = '0;
    any_inv  = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!qry_valid[w]) begin
        inv_way = WAY_W'(w);
        any_inv = 1'b1;
      end
    end
    victim = any_inv ? inv_way : tree_way;
  end

  // Touch: every node on the path points away from the touched way.
  always_comb begin
    int leaf;
    int node;
    int dir;
    tree_d = tree_q[touch_set];
    leaf   = WAYS + int'(touch_way);
    for (int l = 0; l < WAY_W; l++) begin
      node = leaf >> (WAY_W - l);
      dir  = (leaf >> (WAY_W - l - 1)) & 1;
      tree_d[node-1] = (dir == 0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[touch_set] <= tree_d;
    end
  end

  p_victim_invalid_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid != {WAYS{1'b1}}) |-> !qry_valid[victim]);
endmodule

// File: rtl/vipt_tag_dir.sv
module vipt_tag_dir
  import tagdir_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int PPN_W = 24,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [SET_W-1:0] lk_vidx,
  input  logic [PPN_W-1:0] lk_ppn,
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_miss,
  output logic [WAY_W-1:0] res_way,
  output logic [1:0]       res_state,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [PPN_W-1:0] fill_tag,
  input  logic [1:0]       fill_state,
  output logic [WAY_W-1:0] vict_way,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way,
  input  logic [1:0]       upd_state
);
  // Directory storage: tags need no reset; states reset to Invalid.
  logic [WAYS-1:0][PPN_W-1:0] tag_q [SETS];
  logic [WAYS-1:0][1:0]       st_q  [SETS];

  // Stage 1: row snapshot taken at the request edge.
  logic                       s1_v_q;
  logic [SET_W-1:0]           s1_set_q;
  logic [WAYS-1:0][PPN_W-1:0] s1_tags_q;
  logic [WAYS-1:0][1:0]       s1_st_q;
  logic [WAYS-1:0]            s1_valid;

  logic             cmp_hit;
  logic [WAY_W-1:0] cmp_way;
  logic [WAYS-1:0]  fill_valid;
  logic             upd_apply;
  logic             touch_en;
  logic [SET_W-1:0] touch_set;
  logic [WAY_W-1:0] touch_way;

  // Result registers.
  logic             res_valid_q, res_hit_q, res_miss_q;
  logic [WAY_W-1:0] res_way_q;
  logic [1:0]       res_state_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_valid
    assign s1_valid[w]   = (s1_st_q[w] != ST_I);
    assign fill_valid[w] = (st_q[fill_set][w] != ST_I);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_v_q <= 1'b0;
    else        s1_v_q <= lk_req;
  end

  always_ff @(posedge clk) begin
    if (lk_req) begin
      s1_set_q  <= lk_vidx;
      s1_tags_q <= tag_q[lk_vidx];
      s1_st_q   <= st_q[lk_vidx];
    end
  end

  tagdir_cmp #(.WAYS(WAYS), .PPN_W(PPN_W)) cmp_i (
    .row_tags (s1_tags_q),
    .row_valid(s1_valid),
    .ppn      (lk_ppn),
    .hit      (cmp_hit),
    .hit_way  (cmp_way)
  );

  // Stage 2: register the compare outcome.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_hit_q   <= 1'b0;
      res_miss_q  <= 1'b0;
      res_way_q   <= '0;
      res_state_q <= ST_I;
    end else begin
      res_valid_q <= s1_v_q;
      res_hit_q   <= s1_v_q && cmp_hit;
      res_miss_q  <= s1_v_q && !cmp_hit;
      if (s1_v_q) begin
        res_way_q   <= cmp_way;
        res_state_q <= s1_st_q[cmp_way];
      end
    end
  end

  assign res_valid = res_valid_q;
  assign res_hit   = res_hit_q;
  assign res_miss  = res_miss_q;
  assign res_way   = res_way_q;
  assign res_state = res_state_q;

  // Replacement state: one touch per cycle, fill before hit.
  assign touch_en  = fill_en || (s1_v_q && cmp_hit);
  assign touch_set = fill_en ? fill_set : s1_set_q;
  assign touch_way = fill_en ? vict_way : cmp_way;

  tagdir_plru #(.SETS(SETS), .WAYS(WAYS)) plru_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .qry_set  (fill_set),
    .qry_valid(fill_valid),
    .victim   (vict_way),
    .touch_en (touch_en),
    .touch_set(touch_set),
    .touch_way(touch_way)
  );

  assign upd_apply = upd_en &&
    !(fill_en && (fill_set == upd_set) && (vict_way == upd_way));

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_set][vict_way] <= fill_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) st_q[s] <= '0;
    end else begin
      if (upd_apply) st_q[upd_set][upd_way]   <= upd_state;
      if (fill_en)   st_q[fill_set][vict_way] <= fill_state;
    end
  end

  p_res_follows_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> ##1 res_valid);
  p_res_only_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    !s1_v_q |=> !res_valid);
  p_hit_xor_miss_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit ^ res_miss));
  p_idle_quiet_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_hit && !res_miss));
  p_hit_valid_line_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_state != ST_I));
  p_fill_lands_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> st_q[$past(fill_set)][$past(vict_way)] == $past(fill_state));
  p_upd_state_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    upd_apply |=> st_q[$past(upd_set)][$past(upd_way)] == $past(upd_state));
  p_upd_keeps_tag_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !fill_en) |=>
      tag_q[$past(upd_set)][$past(upd_way)] == $past(tag_q[upd_set][upd_way]));
endmodule

// File: tb/vipt_tag_dir_tb.sv
module vipt_tag_dir_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [5:0]  lk_vidx = '0;
  logic [23:0] lk_ppn = '0;
  logic        res_valid, res_hit, res_miss;
  logic [2:0]  res_way;
  logic [1:0]  res_state;
  logic        fill_en = 1'b0;
  logic [5:0]  fill_set = '0;
  logic [23:0] fill_tag = '0;
  logic [1:0]  fill_state = '0;
  logic [2:0]  vict_way;
  logic        upd_en = 1'b0;
  logic [5:0]  upd_set = '0;
  logic [2:0]  upd_way = '0;
  logic [1:0]  upd_state = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vipt_tag_dir dut_i (.*);

  function automatic logic [23:0] tagf(int s, int w);
    return {s[5:0], w[2:0], 15'(15'h1a5 ^ (s * 8 + w))};
  endfunction

  function automatic logic [1:0] stf(int w);
    return 2'((w % 3) + 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_fill(int s, logic [23:0] t, logic [1:0] st, int exp_v, string req);
    @(negedge clk);
    fill_en = 1'b1; fill_set = 6'(s); fill_tag = t; fill_state = st;
    #1;
    chk(vict_way == 3'(exp_v), req, vict_way, exp_v);
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic lookup(int s, logic [23:0] p, bit eh, int ew, int est, string req);
    @(negedge clk);
    lk_req = 1'b1; lk_vidx = 6'(s);
    @(negedge clk);
    lk_req = 1'b0; lk_ppn = p;
    @(negedge clk);
    chk(res_valid && (res_hit == eh) && (res_miss == !eh), req, res_hit, eh);
    if (eh) begin
      chk(res_way == 3'(ew), req, res_way, ew);
      chk(res_state == 2'(est), req, res_state, est);
    end
  endtask

  task automatic update(int s, int w, logic [1:0] st);
    @(negedge clk);
    upd_en = 1'b1; upd_set = 6'(s); upd_way = 3'(w); upd_state = st;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  initial begin
    logic [35:0] pa;
    pa = 36'h0_8000_10a0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!res_valid && !res_hit && !res_miss, "R10", res_valid, 0);
    for (int s = 0; s < 64; s += 21) begin
      fill_set = 6'(s); #1;
      chk(vict_way == 3'd0, "R10", vict_way, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(!res_valid, "R10", res_valid, 0);

    // R11: example address
    chk(int'(pa[11:6]) == 2, "R11", int'(pa[11:6]), 2);
    do_fill(int'(pa[11:6]), pa[35:12], 2'd2, 0, "R11");
    lookup(int'(pa[11:6]), 24'd524289, 1'b1, 0, 2, "R11");
    update(2, 0, 2'd0);
    lookup(2, 24'd524289, 1'b0, 0, 0, "R3");

    // R6/R7: fill every set; victims are the lowest Invalid way
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 8; w++)
        do_fill(s, tagf(s, w), stf(w), w, "R7");

    // R1/R2/R5: hits report way and state; one flipped tag bit misses
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 8; w++) begin
        lookup(s, tagf(s, w), 1'b1, w, stf(w), "R5");
        lookup(s, tagf(s, w) ^ (24'd1 << ((s + w) % 24)), 1'b0, 0, 0, "R2");
      end
    // R1: a tag from another set misses
    lookup(7, tagf(8, 3), 1'b0, 0, 0, "R1");

    // R8: pseudo-LRU once the set is full
    fill_set = 6'd5; #1;
    chk(vict_way == 3'd0, "R8", vict_way, 0);
    do_fill(5, 24'hABCDEF, 2'd1, 0, "R8");
    fill_set = 6'd5; #1;
    chk(vict_way == 3'd4, "R8", vict_way, 4);
    lookup(5, 24'hABCDEF, 1'b1, 0, 1, "R6");
    lookup(5, tagf(5, 4), 1'b1, 4, stf(4), "R8");
    fill_set = 6'd5; #1;
    chk(vict_way == 3'd2, "R8", vict_way, 2);

    // R9: state rewrite keeps the tag
    update(9, 3, 2'd0);
    lookup(9, tagf(9, 3), 1'b0, 0, 0, "R9");
    fill_set = 6'd9; #1;
    chk(vict_way == 3'd3, "R7", vict_way, 3);
    update(9, 3, 2'd3);
    lookup(9, tagf(9, 3), 1'b1, 3, 3, "R9");

    // R4: a single result pulse
    @(negedge clk);
    chk(!res_valid, "R4", res_valid, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule